// File: doc/BRIEF.md
# Sectored Write-Back Cache Controller

This block is a small direct-mapped data cache that sits between a simple CPU request/response port and a lower-level memory. Each cache line shares one tag among several equal sectors, and every sector carries its own valid and dirty flag. Loads and stores are byte-addressed. A response always carries one full sector word, so the byte-offset bits of the address select nothing. Stores use per-byte enables.

Traffic to memory moves in single sectors. A load miss fetches only the addressed sector. A store that covers a whole sector claims it without any read. A partial store to an absent sector fetches that sector first and then merges the enabled bytes. Stores stay in the cache (write-back, allocate on write miss). Only when a different tag takes over a line are that line's modified sectors sent out, one by one, in rising sector order. Only one request is in flight at a time.

With the default parameters there are 8 lines of four 4-byte sectors and an 8-bit byte address. The address fields, from the top, are tag (1 bit), line index (3 bits), sector (2 bits) and byte (2 bits). Memory addresses are sector addresses: the byte address shifted right by two.

Top module: `sector_cache`

## Requirements
- R1: After reset every sector is invalid and clean, the line tags are zero, `reqReady` is 1, and `respValid`, `memRdReqValid` and `memWrValid` are 0.
- R2: A load whose sector is not present issues exactly one memory read, at sector address `reqAddr[7:2]`. The response carries that sector's memory word.
- R3: An access whose tag matches and whose sector is valid causes no memory traffic. `respValid` rises in the first cycle after the request is accepted.
- R4: A store with `reqBe` = 4'b1111 to a sector that is not present causes no memory read. The sector becomes valid and dirty.
- R5: A store with any other non-zero `reqBe` to a sector that is not present first reads that sector. It then replaces byte lane i (bits 8i+7..8i) only where `reqBe[i]` is 1.
- R6: A store to a present sector causes no memory write.
- R7: When a new tag replaces a line, each sector of the old line that is valid and dirty is written exactly once, with its latest data. These writes go in ascending sector order and finish before any read for the new request. Memory then holds every value the CPU stored.
- R8: Replacing a line that holds no dirty sector causes no memory write.
- R9: `reqReady` is 0 from the cycle after acceptance until the response. `respValid` is a one-cycle pulse. Neither memory request is raised while `reqReady` is 1.
- R10: The response word is the addressed sector's content after the access. For a load that is the most recent data stored at that sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | CPU request present |
| reqReady | output | 1 | Controller idle and accepting |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | 8 | Byte address |
| reqWdata | input | 32 | Store data, one sector word |
| reqBe | input | 4 | Store byte enables, bit i = lane i |
| respValid | output | 1 | One-cycle response strobe |
| respRdata | output | 32 | Sector word after the access |
| memRdReqValid | output | 1 | Sector read request |
| memRdReqReady | input | 1 | Memory accepts the read request |
| memRdAddr | output | 6 | Sector address to read |
| memRdDataValid | input | 1 | Read data present |
| memRdData | input | 32 | Read sector word |
| memWrValid | output | 1 | Sector write request |
| memWrReady | input | 1 | Memory accepts the write |
| memWrAddr | output | 6 | Sector address to write |
| memWrData | output | 32 | Sector word to write |

## Verification
A hit has no memory round trip, so its response is due one cycle after the acceptance edge. The bench drives and samples on the falling edge and requires `respValid` at the very first falling edge after acceptance whenever its model predicts no traffic. Misses take a variable number of cycles because the memory model stalls writes and returns read data one cycle after it accepts a read. For those the bench waits for the response pulse and counts the read and write handshakes seen in between, checking their number, addresses and order against its own tag, valid and dirty model. Memory accepts each handshake at the rising edge after the falling edge where both valid and ready are seen, so logging at that falling edge records exactly the accepted transfers.

// File: rtl/sector_cache_pkg.sv
package sector_cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITEBACK,
    ST_FILL,
    ST_RESPOND
  } ctrlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic useIncoming;  // look up the live request instead of the held one
    logic latchReq;     // capture the request
    logic installTag;   // new tag, clear all sector flags of the line
    logic wbClear;      // current write-back sector accepted
    logic fillWrite;    // fill data arrived
    logic commit;       // apply store merge / finish access
  } ctrlStrobe_t;

endpackage

// File: rtl/sector_cache_dp.sv
module sector_cache_dp
  import sector_cache_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3,
  parameter int SEC_W  = 2,
  parameter int BYTE_W = 2,
  localparam int SADDR_W = ADDR_W - BYTE_W,
  localparam int WORD_W  = 8 << BYTE_W,
  localparam int BYTES   = 1 << BYTE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobe_t        strobe,
  input  logic [SADDR_W-1:0] reqSaddr,
  input  logic               reqWrite,
  input  logic [WORD_W-1:0]  reqWdata,
  input  logic [BYTES-1:0]   reqBe,
  input  logic [WORD_W-1:0]  memRdData,
  output logic               tagMatch,
  output logic               secValid,
  output logic               storeCovers,
  output logic               dirtyAny,
  output logic               dirtyOthers,
  output logic [SADDR_W-1:0] memRdAddr,
  output logic [SADDR_W-1:0] memWrAddr,
  output logic [WORD_W-1:0]  memWrData,
  output logic [WORD_W-1:0]  respRdata
);
  localparam int TAG_W   = SADDR_W - IDX_W - SEC_W;
  localparam int NUM_BLK = 1 << IDX_W;
  localparam int NUM_SEC = 1 << SEC_W;

  logic [SADDR_W-1:0] heldSaddr;
  logic               heldWrite;
  logic [WORD_W-1:0]  heldWdata;
  logic [BYTES-1:0]   heldBe;

  logic [TAG_W-1:0]   tagArr   [NUM_BLK];
  logic [NUM_SEC-1:0] validArr [NUM_BLK];
  logic [NUM_SEC-1:0] dirtyArr [NUM_BLK];
  logic [WORD_W-1:0]  dataArr  [NUM_BLK][NUM_SEC];

  logic [SADDR_W-1:0] lookSaddr;
  logic               lookWrite;
  logic [WORD_W-1:0]  lookWdata;
  logic [BYTES-1:0]   lookBe;
  logic [TAG_W-1:0]   lkTag;
  logic [IDX_W-1:0]   lkIdx;
  logic [SEC_W-1:0]   lkSec;
  logic [NUM_SEC-1:0] dirtyVec;
  logic [SEC_W-1:0]   wbPtr;
  logic [WORD_W-1:0]  curWord;
  logic [WORD_W-1:0]  mergedWord;

  assign lookSaddr = strobe.useIncoming ? reqSaddr : heldSaddr;
  assign lookWrite = strobe.useIncoming ? reqWrite : heldWrite;
  assign lookWdata = strobe.useIncoming ? reqWdata : heldWdata;
  assign lookBe    = strobe.useIncoming ? reqBe    : heldBe;

  assign lkTag = lookSaddr[SADDR_W-1 -: TAG_W];
  assign lkIdx = lookSaddr[SEC_W +: IDX_W];
  assign lkSec = lookSaddr[SEC_W-1:0];

  assign tagMatch    = (tagArr[lkIdx] == lkTag);
  assign secValid    = validArr[lkIdx][lkSec];
  assign storeCovers = lookWrite && (&lookBe);
  assign dirtyVec    = dirtyArr[lkIdx] & validArr[lkIdx];
  assign dirtyAny    = |dirtyVec;

  // lowest dirty sector goes first
  always_comb begin
    wbPtr = '0;
    for (int i = NUM_SEC - 1; i >= 0; i--) begin
      if (dirtyVec[i]) wbPtr = SEC_W'(i);
    end
  end

  assign dirtyOthers = |(dirtyVec & ~(NUM_SEC'(1) << wbPtr));

  assign curWord = dataArr[lkIdx][lkSec];

  always_comb begin
    for (int b = 0; b < BYTES; b++) begin
      mergedWord[8*b +: 8] = lookBe[b] ? lookWdata[8*b +: 8] : curWord[8*b +: 8];
    end
  end

  assign respRdata = lookWrite ? mergedWord : curWord;
  assign memRdAddr = lookSaddr;
  assign memWrAddr = {tagArr[lkIdx], lkIdx, wbPtr};
  assign memWrData = dataArr[lkIdx][wbPtr];

  always_ff @(posedge clk) begin
    if (rst) begin
      heldSaddr <= '0;
      heldWrite <= 1'b0;
      heldWdata <= '0;
      heldBe    <= '0;
    end else if (strobe.latchReq) begin
      heldSaddr <= reqSaddr;
      heldWrite <= reqWrite;
      heldWdata <= reqWdata;
      heldBe    <= reqBe;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_BLK; i++) begin
        tagArr[i]   <= '0;
        validArr[i] <= '0;
        dirtyArr[i] <= '0;
      end
    end else begin
      if (strobe.wbClear) dirtyArr[lkIdx][wbPtr] <= 1'b0;
      if (strobe.installTag) begin
        tagArr[lkIdx]   <= lkTag;
        validArr[lkIdx] <= '0;
        dirtyArr[lkIdx] <= '0;
      end
      if (strobe.fillWrite) validArr[lkIdx][lkSec] <= 1'b1;
      if (strobe.commit && lookWrite) begin
        validArr[lkIdx][lkSec] <= 1'b1;
        dirtyArr[lkIdx][lkSec] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillWrite) dataArr[lkIdx][lkSec] <= memRdData;
    else if (strobe.commit && lookWrite) dataArr[lkIdx][lkSec] <= mergedWord;
  end

endmodule

// File: rtl/sector_cache_ctrl.sv
module sector_cache_ctrl
  import sector_cache_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic        tagMatch,
  input  logic        secValid,
  input  logic        storeCovers,
  input  logic        dirtyAny,
  input  logic        dirtyOthers,
  input  logic        memWrReady,
  input  logic        memRdReqReady,
  input  logic        memRdDataValid,
  output ctrlStrobe_t strobe,
  output logic        reqReady,
  output logic        respValid,
  output logic        memWrValid,
  output logic        memRdReqValid
);
  ctrlState_t state, nextState;
  logic       rdIssued;

  always_comb begin
    nextState     = state;
    strobe        = '0;
    reqReady      = 1'b0;
    respValid     = 1'b0;
    memWrValid    = 1'b0;
    memRdReqValid = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady           = 1'b1;
        strobe.useIncoming = 1'b1;
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          if (!tagMatch && dirtyAny) begin
            nextState = ST_WRITEBACK;
          end else if (!tagMatch) begin
            strobe.installTag = 1'b1;
            nextState = storeCovers ? ST_RESPOND : ST_FILL;
          end else begin
            nextState = (secValid || storeCovers) ? ST_RESPOND : ST_FILL;
          end
        end
      end
      ST_WRITEBACK: begin
        memWrValid = 1'b1;
        if (memWrReady) begin
          strobe.wbClear = 1'b1;
          if (!dirtyOthers) begin
            strobe.installTag = 1'b1;
            nextState = storeCovers ? ST_RESPOND : ST_FILL;
          end
        end
      end
      ST_FILL: begin
        memRdReqValid = !rdIssued;
        if (rdIssued && memRdDataValid) begin
          strobe.fillWrite = 1'b1;
          nextState = ST_RESPOND;
        end
      end
      ST_RESPOND: begin
        respValid     = 1'b1;
        strobe.commit = 1'b1;
        nextState     = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      rdIssued <= 1'b0;
    end else begin
      state <= nextState;
      if (strobe.fillWrite) rdIssued <= 1'b0;
      else if (memRdReqValid && memRdReqReady) rdIssued <= 1'b1;
    end
  end

endmodule

// File: rtl/sector_cache.sv
module sector_cache
  import sector_cache_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3,
  parameter int SEC_W  = 2,
  parameter int BYTE_W = 2,
  localparam int SADDR_W = ADDR_W - BYTE_W,
  localparam int WORD_W  = 8 << BYTE_W,
  localparam int BYTES   = 1 << BYTE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [WORD_W-1:0]  reqWdata,
  input  logic [BYTES-1:0]   reqBe,
  output logic               respValid,
  output logic [WORD_W-1:0]  respRdata,
  output logic               memRdReqValid,
  input  logic               memRdReqReady,
  output logic [SADDR_W-1:0] memRdAddr,
  input  logic               memRdDataValid,
  input  logic [WORD_W-1:0]  memRdData,
  output logic               memWrValid,
  input  logic               memWrReady,
  output logic [SADDR_W-1:0] memWrAddr,
  output logic [WORD_W-1:0]  memWrData
);
  ctrlStrobe_t strobe;
  logic tagMatch, secValid, storeCovers, dirtyAny, dirtyOthers;

  sector_cache_ctrl uCtrl (
    .clk(clk), .rst(rst), .reqValid(reqValid),
    .tagMatch(tagMatch), .secValid(secValid), .storeCovers(storeCovers),
    .dirtyAny(dirtyAny), .dirtyOthers(dirtyOthers),
    .memWrReady(memWrReady), .memRdReqReady(memRdReqReady),
    .memRdDataValid(memRdDataValid),
    .strobe(strobe), .reqReady(reqReady), .respValid(respValid),
    .memWrValid(memWrValid), .memRdReqValid(memRdReqValid)
  );

  sector_cache_dp #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SEC_W(SEC_W), .BYTE_W(BYTE_W)
  ) uDp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .reqSaddr(reqAddr[ADDR_W-1:BYTE_W]), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .reqBe(reqBe), .memRdData(memRdData),
    .tagMatch(tagMatch), .secValid(secValid), .storeCovers(storeCovers),
    .dirtyAny(dirtyAny), .dirtyOthers(dirtyOthers),
    .memRdAddr(memRdAddr), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .respRdata(respRdata)
  );

endmodule

// File: rtl/sector_cache_chk.sv
module sector_cache_chk #(
  parameter int SADDR_W = 6,
  parameter int SEC_W   = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               reqReady,
  input logic               respValid,
  input logic               memRdReqValid,
  input logic               memRdReqReady,
  input logic [SADDR_W-1:0] memRdAddr,
  input logic               memWrValid,
  input logic               memWrReady,
  input logic [SADDR_W-1:0] memWrAddr
);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> reqReady && !respValid && !memWrValid && !memRdReqValid);

  assert_resp_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    respValid |=> !respValid);

  assert_busy_on_resp_R9: assert property (@(posedge clk) disable iff (rst)
    respValid |-> !reqReady);

  assert_idle_no_mem_R9: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> !memWrValid && !memRdReqValid);

  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (rst)
    memRdReqValid && !memRdReqReady |=> memRdReqValid && $stable(memRdAddr));

  assert_wr_hold_R7: assert property (@(posedge clk) disable iff (rst)
    memWrValid && !memWrReady |=> memWrValid && $stable(memWrAddr));

  assert_wb_ascending_R7: assert property (@(posedge clk) disable iff (rst)
    memWrValid && memWrReady |=> !memWrValid ||
      ((memWrAddr[SADDR_W-1:SEC_W] == $past(memWrAddr[SADDR_W-1:SEC_W])) &&
       (memWrAddr[SEC_W-1:0] > $past(memWrAddr[SEC_W-1:0]))));

  assert_wb_before_fill_R7: assert property (@(posedge clk) disable iff (rst)
    !(memWrValid && memRdReqValid));

endmodule

bind sector_cache sector_cache_chk #(
  .SADDR_W(ADDR_W - BYTE_W), .SEC_W(SEC_W)
) uChk (
  .clk(clk), .rst(rst), .reqReady(reqReady), .respValid(respValid),
  .memRdReqValid(memRdReqValid), .memRdReqReady(memRdReqReady),
  .memRdAddr(memRdAddr), .memWrValid(memWrValid), .memWrReady(memWrReady),
  .memWrAddr(memWrAddr)
);

// File: tb/tb_sector_cache.sv
`timescale 1ns/1ps
module tb_sector_cache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [3:0]  reqBe = '0;
  logic        respValid;
  logic [31:0] respRdata;
  logic        memRdReqValid;
  logic        memRdReqReady = 1'b1;
  logic [5:0]  memRdAddr;
  logic        memRdDataValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic        memWrValid;
  logic        memWrReady = 1'b0;
  logic [5:0]  memWrAddr;
  logic [31:0] memWrData;

  always #2.5 clk = ~clk;

  sector_cache dut (.*);

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  logic [31:0] mainMem [64];
  logic [31:0] gmem [64];
  logic        mTag [8];
  logic [3:0]  mVal [8];
  logic [3:0]  mDirty [8];

  int          rdCount = 0;
  logic [5:0]  rdLastAddr = '0;
  int          wrLogN = 0;
  logic [5:0]  wrLogAddr [8];
  logic [31:0] wrLogData [8];
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [15:0] lfsrNext(input logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // memory model: decisions at falling edge, accepted at next rising edge
  initial begin
    logic       rdPend;
    logic [5:0] rdQ;
    logic [15:0] stall;
    rdPend = 0; rdQ = '0; stall = 16'h1D2B;
    forever begin
      @(negedge clk);
      if (rdPend) begin
        memRdDataValid = 1'b1;
        memRdData = mainMem[rdQ];
        rdPend = 0;
      end else begin
        memRdDataValid = 1'b0;
      end
      if (!rst && memRdReqValid && memRdReqReady) begin
        rdPend = 1; rdQ = memRdAddr; rdLastAddr = memRdAddr; rdCount++;
      end
      stall = lfsrNext(stall);
      memWrReady = stall[0] | stall[3];
      if (!rst && memWrValid && memWrReady) begin
        mainMem[memWrAddr] = memWrData;
        if (wrLogN < 8) begin
          wrLogAddr[wrLogN] = memWrAddr;
          wrLogData[wrLogN] = memWrData;
        end
        wrLogN++;
      end
    end
  end

  task automatic doOp(input bit wr, input logic [7:0] addr,
                      input logic [31:0] wd, input logic [3:0] be);
    logic [5:0]  sa;
    logic [2:0]  ix;
    logic [1:0]  s;
    logic        t;
    logic [3:0]  dv;
    logic [5:0]  expWA [4];
    logic [31:0] expWD [4];
    int expRd, expWr, rd0, lat;
    bit miss, full, busy;
    string rdTag, wrTag;
    sa = addr[7:2]; ix = sa[4:2]; s = sa[1:0]; t = sa[5];
    miss = (mTag[ix] != t);
    expWr = 0;
    if (miss) begin
      dv = mVal[ix] & mDirty[ix];
      for (int k = 0; k < 4; k++) begin
        if (dv[k]) begin
          expWA[expWr] = {mTag[ix], ix, 2'(k)};
          expWD[expWr] = gmem[{mTag[ix], ix, 2'(k)}];
          expWr++;
        end
      end
      mTag[ix] = t; mVal[ix] = '0; mDirty[ix] = '0;
    end
    full = wr && (be == 4'hF);
    expRd = (!mVal[ix][s] && !full) ? 1 : 0;
    mVal[ix][s] = 1'b1;
    if (wr) begin
      mDirty[ix][s] = 1'b1;
      for (int b = 0; b < 4; b++) if (be[b]) gmem[sa][8*b +: 8] = wd[8*b +: 8];
    end
    if (!wr) rdTag = "R2";
    else if (full) rdTag = "R4";
    else rdTag = "R5";
    if (!miss) wrTag = "R6";
    else if (expWr > 0) wrTag = "R7";
    else wrTag = "R8";

    @(negedge clk);
    rd0 = rdCount; wrLogN = 0;
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wd; reqBe = be;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1; busy = 0;
    while (!respValid && lat < 300) begin
      if (reqReady) busy = 1;
      @(negedge clk);
      lat++;
    end
    if (reqReady) busy = 1;
    chk("R9", "busy while pending", 32'(busy), 32'd0);
    chk("R10", "response word", respRdata, gmem[sa]);
    chk(wrTag, "write count", 32'(wrLogN), 32'(expWr));
    for (int k = 0; k < expWr && k < wrLogN && k < 8; k++) begin
      chk("R7", "write-back address", 32'(wrLogAddr[k]), 32'(expWA[k]));
      chk("R7", "write-back data", wrLogData[k], expWD[k]);
    end
    chk(expRd ? rdTag : (wr ? rdTag : "R3"), "read count", 32'(rdCount - rd0), 32'(expRd));
    if (expRd == 1) chk(rdTag, "read address", 32'(rdLastAddr), 32'(sa));
    if (expRd == 0 && expWr == 0) chk("R3", "hit latency", 32'(lat), 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mainMem[i] = 32'hA500_0000 ^ (32'(i) * 32'h0103_0507);
      gmem[i] = mainMem[i];
    end
    for (int i = 0; i < 8; i++) begin
      mTag[i] = 1'b0; mVal[i] = '0; mDirty[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "reqReady after reset", 32'(reqReady), 32'd1);
    chk("R1", "respValid after reset", 32'(respValid), 32'd0);
    chk("R1", "memRdReqValid after reset", 32'(memRdReqValid), 32'd0);
    chk("R1", "memWrValid after reset", 32'(memWrValid), 32'd0);

    // every sector loaded once: fills, then clean replacements for the upper tag
    for (int i = 0; i < 64; i++) doOp(1'b0, {6'(i), 2'(i)}, 32'h0, 4'h0);
    // hits on the resident half
    for (int i = 32; i < 64; i++) doOp(1'b0, {6'(i), 2'(i + 1)}, 32'h0, 4'h0);
    // stores to the other tag with every byte-enable pattern
    for (int i = 0; i < 32; i++)
      doOp(1'b1, {6'(i), 2'b00}, 32'hC0DE_0000 | 32'(i * 7), 4'((i % 15) + 1));
    // store hits, then dirty replacement
    for (int i = 0; i < 32; i += 3) doOp(1'b1, {6'(i), 2'b01}, 32'h5A5A_0000 | 32'(i), 4'hF);
    for (int i = 32; i < 64; i++) doOp(1'b0, {6'(i), 2'b00}, 32'h0, 4'h0);

    // pseudo-random mix
    for (int n = 0; n < 700; n++) begin
      logic [3:0] be;
      logic [5:0] sa;
      lfsr = lfsrNext(lfsr); lfsr = lfsrNext(lfsr);
      sa = lfsr[9:4];
      be = lfsr[13] ? 4'hF : ((lfsr[3:0] == 0) ? 4'h6 : lfsr[3:0]);
      lfsr = lfsrNext(lfsr);
      doOp(lfsr[0] ^ lfsr[7], {sa, lfsr[2:1]}, {lfsr, ~lfsr} ^ 32'(n), be);
    end

    // replace every line so all dirty sectors reach memory
    for (int i = 0; i < 8; i++) doOp(1'b0, {~mTag[i], 3'(i), 2'b00, 2'b00}, 32'h0, 4'h0);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 64; i++) chk("R7", "memory after flush", mainMem[i], gmem[i]);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule